// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This block sits beside an SMBus host controller and handles the data side of block transfers. It owns a byte buffer with a running index and a single holding register. It moves bytes between the software-facing block data port, the buffer and the bus engine. The register decode, the status register and the bus signalling all sit outside. The block reports what happened through one-cycle event strobes: interrupt, byte done, busy set, busy clear and device error. It also sends requests to the bus engine: send the block, fetch one byte, and issue a stop.

Two modes share the buffer. When the buffered-mode control bit is set, software fills the whole buffer before a block write, or drains it after a block read, through the block data port. Each access post-increments the index. When the bit is clear, the transfer runs one byte at a time through the holding register. Software paces each step by acknowledging byte done. A separate I2C-style block read fetches bytes from the bus one at a time into the holding register. A new start command aborts any unfinished operation.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset, no event or request output is active, the block is idle with index 0, and the block data read port returns the holding register, whose value is 0.
- R2: With buffered mode set and no I2C read running, a host write to the block data port stores the byte at the index and then increments the index. If the index equals DEPTH before an access, the access uses entry 0 instead.
- R3: A buffered block-write start compares the index with the count input. If they are equal, the block raises sendReq, interrupt and busy clear. If they differ, it raises device error. In both cases the index returns to 0.
- R4: For a buffered block read, a received count raises cntLoad. After that many bus bytes have been stored, interrupt is raised. Each block data read then returns buffer[index] and increments the index. When the index reaches the count, busy clear is raised and the index returns to 0.
- R5: A byte-by-byte block-write start copies the holding register into entry 0, resets the index and raises busy set and byte done.
- R6: During a byte-by-byte write, each byte-done acknowledge advances the index. If the new index equals the count, the block raises sendReq, interrupt and busy clear. Otherwise the holding register is stored at the new index and byte done is raised.
- R7: A byte-by-byte block read loads entry 0 into the holding register once all bytes have arrived, and raises busy set and byte done. For a count of 1 the arriving byte is used directly. Each acknowledge advances the index and loads buffer[index] into the holding register. If the last-byte bit is set, it also raises interrupt and busy clear and ends the operation. Otherwise it raises byte done.
- R8: A start command that arrives while an operation is unfinished resets the index before the new start is evaluated. If the unfinished operation is an I2C read, stopReq is also raised.
- R9: An I2C block read raises fetchReq and busy set at its start. Each arriving byte goes into the holding register and raises byte done. An acknowledge raises fetchReq, and also stopReq when the last-byte bit is set. The byte after a last acknowledge raises interrupt and busy clear. During the read, block data port accesses reach only the holding register.
- R10: A received count of 0 or greater than DEPTH raises device error and ends the read. No cntLoad is raised, and later bus bytes are ignored.
- R11: With buffered mode clear, block data writes load only the holding register, and block data reads return it without moving the index.
- R12: A byte-done acknowledge when no byte-paced operation is pending has no effect and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBuffered | input | 1 | Buffered-mode control bit |
| cfgLastByte | input | 1 | Last-byte control bit |
| cfgCount | input | DW | Byte count register value |
| startBlkWr | input | 1 | Block-write start pulse |
| startBlkRd | input | 1 | Block-read start pulse |
| startI2cRd | input | 1 | I2C block-read start pulse |
| hostWrEn | input | 1 | Block data port write strobe |
| hostWrData | input | DW | Block data port write byte |
| hostRdEn | input | 1 | Block data port read strobe |
| hostRdData | output | DW | Block data port read byte |
| byteDoneAck | input | 1 | Software cleared byte done |
| rxCountValid | input | 1 | Received block count valid |
| rxCount | input | DW | Received block count |
| rxByteValid | input | 1 | Received data byte valid |
| rxByte | input | DW | Received data byte |
| sendIdx | input | AW | Bus engine buffer read index |
| sendData | output | DW | Buffer byte at sendIdx |
| sendLen | output | DW | Length of the block to send |
| sendReq | output | 1 | Send buffered block |
| fetchReq | output | 1 | Fetch one byte from the bus |
| stopReq | output | 1 | Terminate the I2C read with a stop |
| cntLoad | output | 1 | Load received count into the count register |
| evtIntr | output | 1 | Set interrupt status |
| evtByteDone | output | 1 | Set byte-done status |
| evtBusySet | output | 1 | Set host busy |
| evtBusyClr | output | 1 | Clear host busy |
| evtDevErr | output | 1 | Set device error |

## Verification
The bench builds the block with its default DEPTH of 32 and an 8-bit data width, so a full buffer takes only 32 host writes. A 33rd write reaches the wrap of the index back to entry 0. The same depth brings both ends of the count range within reach. A count of 32 matches an index that has stopped at DEPTH, and a received count of 33 must be rejected as out of range.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_BYTE,
    ST_RD_COUNT,
    ST_RD_FILL,
    ST_RD_DRAIN,
    ST_RD_BYTE,
    ST_I2C_WAIT,
    ST_I2C_HOLD
  } state_e;

  // Source of a byte written into the buffer
  typedef enum logic [1:0] {
    WSRC_HOST,
    WSRC_HOLD,
    WSRC_BUS
  } wsrc_e;

  // Source of a byte loaded into the holding register
  typedef enum logic [1:0] {
    HSRC_HOST,
    HSRC_BUS,
    HSRC_BUF
  } hsrc_e;

  typedef struct packed {
    logic  bufWe;
    wsrc_e bufSrc;
    logic  holdWe;
    hsrc_e holdSrc;
    logic  showBuf;
  } strobe_t;

endpackage

// File: rtl/smbblk_datapath.sv
module smbblk_datapath
  import smbblk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [AW-1:0] sendIdx,
  input  logic [DW-1:0] hostData,
  input  logic [DW-1:0] busData,
  output logic [DW-1:0] hostRdData,
  output logic [DW-1:0] sendData
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] holdQ;
  logic [DW-1:0] memWData;
  logic [DW-1:0] holdD;

  always_comb begin
    case (stb.bufSrc)
      WSRC_HOLD: memWData = holdQ;
      WSRC_BUS:  memWData = busData;
      default:   memWData = hostData;
    endcase
  end

  always_comb begin
    case (stb.holdSrc)
      HSRC_BUS: holdD = busData;
      HSRC_BUF: holdD = mem[rdAddr];
      default:  holdD = hostData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.bufWe) mem[wrAddr] <= memWData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           holdQ <= '0;
    else if (stb.holdWe) holdQ <= holdD;
  end

  assign hostRdData = stb.showBuf ? mem[rdAddr] : holdQ;
  assign sendData   = mem[sendIdx];

  // R11: one host byte lands in exactly one place
  assert_host_single_dest_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.holdWe && stb.holdSrc == HSRC_HOST && stb.bufWe && stb.bufSrc == WSRC_HOST));

  // R1: holding register keeps its value unless the control asks for a load
  assert_hold_keeps_R1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.holdWe |=> $stable(holdQ));

endmodule

// File: rtl/smbblk_ctl.sv
module smbblk_ctl
  import smbblk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgBuffered,
  input  logic          cfgLastByte,
  input  logic [DW-1:0] cfgCount,
  input  logic          startBlkWr,
  input  logic          startBlkRd,
  input  logic          startI2cRd,
  input  logic          hostWrEn,
  input  logic          hostRdEn,
  input  logic          byteDoneAck,
  input  logic          rxCountValid,
  input  logic [DW-1:0] rxCount,
  input  logic          rxByteValid,
  output strobe_t       stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          sendReq,
  output logic          fetchReq,
  output logic          stopReq,
  output logic          cntLoad,
  output logic          evtIntr,
  output logic          evtByteDone,
  output logic          evtBusySet,
  output logic          evtBusyClr,
  output logic          evtDevErr
);

  state_e        state, stateN;
  logic [IW-1:0] idx, idxN;
  logic [IW-1:0] fillPtr, fillPtrN;
  logic [IW-1:0] fillLen, fillLenN;
  logic          lastPend, lastPendN;

  logic [IW-1:0] idxW, idxInc, idxStep, idxAdv, idxBase, fillInc;
  logic          inI2c, bufMode, startAny, countOk;

  always_comb begin
    idxW     = (idx >= IW'(DEPTH)) ? '0 : idx;
    idxInc   = idxW + IW'(1);
    idxStep  = idx + IW'(1);
    idxAdv   = (idxStep >= IW'(DEPTH)) ? '0 : idxStep;
    fillInc  = fillPtr + IW'(1);
    inI2c    = (state == ST_I2C_WAIT) || (state == ST_I2C_HOLD);
    bufMode  = cfgBuffered && !inI2c;
    startAny = startBlkWr || startBlkRd || startI2cRd;
    idxBase  = (state != ST_IDLE) ? '0 : idx;
    countOk  = (rxCount != '0) && (rxCount <= DW'(DEPTH));
  end

  always_comb begin
    stateN      = state;
    idxN        = idx;
    fillPtrN    = fillPtr;
    fillLenN    = fillLen;
    lastPendN   = lastPend;
    stb         = '0;
    stb.showBuf = bufMode;
    wrAddr      = idxW[AW-1:0];
    rdAddr      = idxW[AW-1:0];
    sendReq     = 1'b0;
    fetchReq    = 1'b0;
    stopReq     = 1'b0;
    cntLoad     = 1'b0;
    evtIntr     = 1'b0;
    evtByteDone = 1'b0;
    evtBusySet  = 1'b0;
    evtBusyClr  = 1'b0;
    evtDevErr   = 1'b0;

    if (startAny) begin
      stopReq = inI2c;
      idxN    = '0;
      if (startBlkWr) begin
        if (cfgBuffered) begin
          if (DW'(idxBase) == cfgCount) begin
            sendReq    = 1'b1;
            evtIntr    = 1'b1;
            evtBusyClr = 1'b1;
          end else begin
            evtDevErr = 1'b1;
          end
          stateN = ST_IDLE;
        end else begin
          stb.bufWe   = 1'b1;
          stb.bufSrc  = WSRC_HOLD;
          wrAddr      = '0;
          evtBusySet  = 1'b1;
          evtByteDone = 1'b1;
          stateN      = ST_WR_BYTE;
        end
      end else if (startBlkRd) begin
        stateN = ST_RD_COUNT;
      end else begin
        fetchReq   = 1'b1;
        evtBusySet = 1'b1;
        lastPendN  = 1'b0;
        stateN     = ST_I2C_WAIT;
      end
    end else begin
      if (hostWrEn) begin
        if (bufMode) begin
          stb.bufWe  = 1'b1;
          stb.bufSrc = WSRC_HOST;
          idxN       = idxInc;
        end else begin
          stb.holdWe  = 1'b1;
          stb.holdSrc = HSRC_HOST;
        end
      end else if (hostRdEn && bufMode) begin
        idxN = idxInc;
        if (state == ST_RD_DRAIN && DW'(idxInc) == cfgCount) begin
          evtBusyClr = 1'b1;
          idxN       = '0;
          stateN     = ST_IDLE;
        end
      end

      case (state)
        ST_WR_BYTE: if (byteDoneAck) begin
          if (DW'(idxAdv) == cfgCount) begin
            sendReq    = 1'b1;
            evtIntr    = 1'b1;
            evtBusyClr = 1'b1;
            idxN       = '0;
            stateN     = ST_IDLE;
          end else begin
            stb.bufWe   = 1'b1;
            stb.bufSrc  = WSRC_HOLD;
            wrAddr      = idxAdv[AW-1:0];
            evtByteDone = 1'b1;
            idxN        = idxAdv;
          end
        end
        ST_RD_COUNT: if (rxCountValid) begin
          if (countOk) begin
            cntLoad  = 1'b1;
            fillLenN = rxCount[IW-1:0];
            fillPtrN = '0;
            stateN   = ST_RD_FILL;
          end else begin
            evtDevErr = 1'b1;
            stateN    = ST_IDLE;
          end
        end
        ST_RD_FILL: if (rxByteValid) begin
          stb.bufWe  = 1'b1;
          stb.bufSrc = WSRC_BUS;
          wrAddr     = fillPtr[AW-1:0];
          fillPtrN   = fillInc;
          if (fillInc == fillLen) begin
            idxN = '0;
            if (cfgBuffered) begin
              evtIntr = 1'b1;
              stateN  = ST_RD_DRAIN;
            end else begin
              stb.holdWe  = 1'b1;
              stb.holdSrc = (fillPtr == '0) ? HSRC_BUS : HSRC_BUF;
              rdAddr      = '0;
              evtBusySet  = 1'b1;
              evtByteDone = 1'b1;
              stateN      = ST_RD_BYTE;
            end
          end
        end
        ST_RD_BYTE: if (byteDoneAck) begin
          rdAddr      = idxAdv[AW-1:0];
          stb.holdWe  = 1'b1;
          stb.holdSrc = HSRC_BUF;
          if (cfgLastByte) begin
            evtIntr    = 1'b1;
            evtBusyClr = 1'b1;
            idxN       = '0;
            stateN     = ST_IDLE;
          end else begin
            evtByteDone = 1'b1;
            idxN        = idxAdv;
          end
        end
        ST_I2C_WAIT: if (rxByteValid) begin
          stb.holdWe  = 1'b1;
          stb.holdSrc = HSRC_BUS;
          if (lastPend) begin
            evtIntr    = 1'b1;
            evtBusyClr = 1'b1;
            idxN       = '0;
            stateN     = ST_IDLE;
          end else begin
            evtByteDone = 1'b1;
            stateN      = ST_I2C_HOLD;
          end
        end
        ST_I2C_HOLD: if (byteDoneAck) begin
          idxN     = idxAdv;
          fetchReq = 1'b1;
          if (cfgLastByte) begin
            stopReq   = 1'b1;
            lastPendN = 1'b1;
          end
          stateN = ST_I2C_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      fillPtr  <= '0;
      fillLen  <= '0;
      lastPend <= 1'b0;
    end else begin
      state    <= stateN;
      idx      <= idxN;
      fillPtr  <= fillPtrN;
      fillLen  <= fillLenN;
      lastPend <= lastPendN;
    end
  end

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    idx <= IW'(DEPTH));

  assert_err_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(evtDevErr && evtIntr));

  assert_send_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    sendReq |=> (state == ST_IDLE));

  assert_bd_not_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    evtByteDone |-> !evtBusyClr);

  assert_stop_with_fetch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !startAny) |-> fetchReq);

endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf
  import smbblk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgBuffered,
  input  logic          cfgLastByte,
  input  logic [DW-1:0] cfgCount,
  input  logic          startBlkWr,
  input  logic          startBlkRd,
  input  logic          startI2cRd,
  input  logic          hostWrEn,
  input  logic [DW-1:0] hostWrData,
  input  logic          hostRdEn,
  output logic [DW-1:0] hostRdData,
  input  logic          byteDoneAck,
  input  logic          rxCountValid,
  input  logic [DW-1:0] rxCount,
  input  logic          rxByteValid,
  input  logic [DW-1:0] rxByte,
  input  logic [AW-1:0] sendIdx,
  output logic [DW-1:0] sendData,
  output logic [DW-1:0] sendLen,
  output logic          sendReq,
  output logic          fetchReq,
  output logic          stopReq,
  output logic          cntLoad,
  output logic          evtIntr,
  output logic          evtByteDone,
  output logic          evtBusySet,
  output logic          evtBusyClr,
  output logic          evtDevErr
);

  strobe_t       stb;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  assign sendLen = cfgCount;

  smbblk_ctl #(.DEPTH(DEPTH), .DW(DW)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgBuffered (cfgBuffered),
    .cfgLastByte (cfgLastByte),
    .cfgCount    (cfgCount),
    .startBlkWr  (startBlkWr),
    .startBlkRd  (startBlkRd),
    .startI2cRd  (startI2cRd),
    .hostWrEn    (hostWrEn),
    .hostRdEn    (hostRdEn),
    .byteDoneAck (byteDoneAck),
    .rxCountValid(rxCountValid),
    .rxCount     (rxCount),
    .rxByteValid (rxByteValid),
    .stb         (stb),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .sendReq     (sendReq),
    .fetchReq    (fetchReq),
    .stopReq     (stopReq),
    .cntLoad     (cntLoad),
    .evtIntr     (evtIntr),
    .evtByteDone (evtByteDone),
    .evtBusySet  (evtBusySet),
    .evtBusyClr  (evtBusyClr),
    .evtDevErr   (evtDevErr)
  );

  smbblk_datapath #(.DEPTH(DEPTH), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .sendIdx   (sendIdx),
    .hostData  (hostWrData),
    .busData   (rxByte),
    .hostRdData(hostRdData),
    .sendData  (sendData)
  );

endmodule

// File: tb/smbus_blkbuf_bench.sv
module smbus_blkbuf_bench;

  localparam int DEPTH = 32;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);

  // operations
  localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_SW = 4'd2, OP_SR = 4'd3,
                         OP_RC = 4'd4, OP_RB = 4'd5, OP_AK = 4'd6, OP_SI = 4'd7;
  // event mask {send,intr,byteDone,busySet,busyClr,devErr,cntLoad,fetch,stop}
  localparam logic [8:0] E0 = 9'h000, ESND = 9'h100, EINT = 9'h080, EBD = 9'h040,
                         EBS = 9'h020, EBC = 9'h010, EERR = 9'h008, ECNT = 9'h004,
                         EFET = 9'h002, ESTP = 9'h001;

  typedef struct packed {
    logic [3:0] op;
    logic       bf;
    logic       lst;
    logic [7:0] cnt;
    logic [7:0] arg;
    logic [8:0] ev;
    logic       chk;
    logic [7:0] rd;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(logic [3:0] op, logic bf, logic lst, logic [7:0] cnt,
                              logic [7:0] arg, logic [8:0] ev, logic chk,
                              logic [7:0] rd, logic [3:0] req);
    mk = '{op, bf, lst, cnt, arg, ev, chk, rd, req};
  endfunction

  localparam int NV = 41;
  localparam vec_t TBL [0:NV-1] = '{
    mk(OP_WR,1,0,3,8'h11,E0,0,0,2),            // R2 buffered fill
    mk(OP_WR,1,0,3,8'h22,E0,0,0,2),
    mk(OP_WR,1,0,3,8'h33,E0,0,0,2),
    mk(OP_SW,1,0,3,0,ESND|EINT|EBC,0,0,3),     // R3 match
    mk(OP_WR,1,0,3,8'h44,E0,0,0,2),
    mk(OP_SW,1,0,3,0,EERR,0,0,3),              // R3 mismatch
    mk(OP_SR,1,0,2,0,E0,0,0,4),                // R4 buffered read
    mk(OP_RC,1,0,2,8'd2,ECNT,0,0,4),
    mk(OP_RB,1,0,2,8'hA1,E0,0,0,4),
    mk(OP_RB,1,0,2,8'hA2,EINT,0,0,4),
    mk(OP_RD,1,0,2,0,E0,1,8'hA1,4),
    mk(OP_RD,1,0,2,0,EBC,1,8'hA2,4),
    mk(OP_SR,1,0,2,0,E0,0,0,10),               // R10 zero count
    mk(OP_RC,1,0,2,8'd0,EERR,0,0,10),
    mk(OP_RB,1,0,2,8'h55,E0,0,0,10),
    mk(OP_SR,1,0,2,0,E0,0,0,10),               // R10 oversize count
    mk(OP_RC,1,0,2,8'd33,EERR,0,0,10),
    mk(OP_AK,0,0,3,0,E0,0,0,12),               // R12 idle acknowledge
    mk(OP_WR,0,0,3,8'h61,E0,0,0,11),           // R11 hold write
    mk(OP_SW,0,0,3,0,EBS|EBD,0,0,5),           // R5
    mk(OP_WR,0,0,3,8'h62,E0,0,0,11),
    mk(OP_AK,0,0,3,0,EBD,0,0,6),               // R6
    mk(OP_WR,0,0,3,8'h63,E0,0,0,11),
    mk(OP_AK,0,0,3,0,EBD,0,0,6),
    mk(OP_AK,0,0,3,0,ESND|EINT|EBC,0,0,6),
    mk(OP_SR,0,0,3,0,E0,0,0,7),                // R7 byte-paced read
    mk(OP_RC,0,0,3,8'd3,ECNT,0,0,7),
    mk(OP_RB,0,0,3,8'hB1,E0,0,0,7),
    mk(OP_RB,0,0,3,8'hB2,E0,0,0,7),
    mk(OP_RB,0,0,3,8'hB3,EBS|EBD,0,0,7),
    mk(OP_RD,0,0,3,0,E0,1,8'hB1,11),           // R11 read returns hold
    mk(OP_AK,0,0,3,0,EBD,0,0,7),
    mk(OP_RD,0,0,3,0,E0,1,8'hB2,7),
    mk(OP_AK,0,1,3,0,EINT|EBC,0,0,7),
    mk(OP_RD,0,0,3,0,E0,1,8'hB3,7),
    mk(OP_SR,0,0,1,0,E0,0,0,7),                // R7 single byte bypass
    mk(OP_RC,0,0,1,8'd1,ECNT,0,0,7),
    mk(OP_RB,0,0,1,8'hC1,EBS|EBD,0,0,7),
    mk(OP_RD,0,0,1,0,E0,1,8'hC1,7),
    mk(OP_AK,0,1,1,0,EINT|EBC,0,0,7),
    mk(OP_RD,0,0,1,0,E0,1,8'hB2,7)
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgBuffered, cfgLastByte;
  logic [DW-1:0] cfgCount;
  logic          startBlkWr, startBlkRd, startI2cRd;
  logic          hostWrEn, hostRdEn, byteDoneAck;
  logic [DW-1:0] hostWrData, hostRdData;
  logic          rxCountValid, rxByteValid;
  logic [DW-1:0] rxCount, rxByte;
  logic [AW-1:0] sendIdx;
  logic [DW-1:0] sendData, sendLen;
  logic          sendReq, fetchReq, stopReq, cntLoad;
  logic          evtIntr, evtByteDone, evtBusySet, evtBusyClr, evtDevErr;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  smbus_blkbuf #(.DEPTH(DEPTH), .DW(DW)) u_smbus_blkbuf (
    .clk(clk), .rstN(rstN), .cfgBuffered(cfgBuffered), .cfgLastByte(cfgLastByte),
    .cfgCount(cfgCount), .startBlkWr(startBlkWr), .startBlkRd(startBlkRd),
    .startI2cRd(startI2cRd), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .byteDoneAck(byteDoneAck),
    .rxCountValid(rxCountValid), .rxCount(rxCount), .rxByteValid(rxByteValid),
    .rxByte(rxByte), .sendIdx(sendIdx), .sendData(sendData), .sendLen(sendLen),
    .sendReq(sendReq), .fetchReq(fetchReq), .stopReq(stopReq), .cntLoad(cntLoad),
    .evtIntr(evtIntr), .evtByteDone(evtByteDone), .evtBusySet(evtBusySet),
    .evtBusyClr(evtBusyClr), .evtDevErr(evtDevErr)
  );

  function automatic logic [8:0] evNow();
    evNow = {sendReq, evtIntr, evtByteDone, evtBusySet, evtBusyClr, evtDevErr,
             cntLoad, fetchReq, stopReq};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    startBlkWr = 0; startBlkRd = 0; startI2cRd = 0;
    hostWrEn = 0; hostRdEn = 0; byteDoneAck = 0;
    rxCountValid = 0; rxByteValid = 0;
  endtask

  task automatic apply(input logic [3:0] op, input logic bf, input logic lst,
                       input logic [7:0] cnt, input logic [7:0] arg,
                       output logic [8:0] ev, output logic [7:0] rd);
    @(negedge clk);
    cfgBuffered = bf; cfgLastByte = lst; cfgCount = cnt;
    case (op)
      OP_WR: begin hostWrEn = 1; hostWrData = arg; end
      OP_RD: hostRdEn = 1;
      OP_SW: startBlkWr = 1;
      OP_SR: startBlkRd = 1;
      OP_RC: begin rxCountValid = 1; rxCount = arg; end
      OP_RB: begin rxByteValid = 1; rxByte = arg; end
      OP_AK: byteDoneAck = 1;
      OP_SI: startI2cRd = 1;
      default: ;
    endcase
    #1;
    ev = evNow();
    rd = hostRdData;
    @(posedge clk);
    #1;
    clearIn();
  endtask

  task automatic stepEv(input string req, input logic [3:0] op, input logic bf,
                        input logic lst, input logic [7:0] cnt, input logic [7:0] arg,
                        input logic [8:0] expEv);
    logic [8:0] ev;
    logic [7:0] rd;
    apply(op, bf, lst, cnt, arg, ev, rd);
    check(req, 16'(ev), 16'(expEv));
  endtask

  task automatic stepRd(input string req, input logic bf, input logic [7:0] expRd);
    logic [8:0] ev;
    logic [7:0] rd;
    apply(OP_RD, bf, 0, 0, 0, ev, rd);
    check(req, 16'(rd), 16'(expRd));
  endtask

  task automatic peekSend(input string req, input int i, input logic [7:0] exp);
    @(negedge clk);
    sendIdx = AW'(i);
    #1;
    check(req, 16'(sendData), 16'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] ev;
    logic [7:0] rd;
    rstN = 0; cfgBuffered = 0; cfgLastByte = 0; cfgCount = 0;
    hostWrData = 0; rxCount = 0; rxByte = 0; sendIdx = 0;
    clearIn();
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    @(negedge clk);
    check("R1 events", 16'(evNow()), 16'h0);
    check("R1 hold", 16'(hostRdData), 16'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].op, TBL[i].bf, TBL[i].lst, TBL[i].cnt, TBL[i].arg, ev, rd);
      check($sformatf("R%0d vec%0d ev", TBL[i].req, i), 16'(ev), 16'(TBL[i].ev));
      if (TBL[i].chk)
        check($sformatf("R%0d vec%0d rd", TBL[i].req, i), 16'(rd), 16'(TBL[i].rd));
    end

    // R6 contents sent after a byte-paced write
    stepEv("R11", OP_WR, 0, 0, 2, 8'h71, E0);
    stepEv("R5", OP_SW, 0, 0, 2, 0, EBS | EBD);
    stepEv("R11", OP_WR, 0, 0, 2, 8'h72, E0);
    stepEv("R6", OP_AK, 0, 0, 2, 0, EBD);
    stepEv("R6 send", OP_AK, 0, 0, 2, 0, ESND | EINT | EBC);
    peekSend("R6 byte0", 0, 8'h71);
    peekSend("R6 byte1", 1, 8'h72);

    // R2 index wrap: 33 buffered writes land the last one in entry 0
    for (int k = 0; k < 33; k++) apply(OP_WR, 1, 0, 1, 8'(k + 1), ev, rd);
    stepEv("R2 wrap start", OP_SW, 1, 0, 1, 0, ESND | EINT | EBC);
    peekSend("R2 wrapped entry0", 0, 8'h21);
    peekSend("R2 entry1", 1, 8'h02);
    peekSend("R2 entry31", 31, 8'h20);

    // R3 full buffer: index parked at DEPTH matches count 32
    for (int k = 0; k < 32; k++) apply(OP_WR, 1, 0, 32, 8'(8'h80 + k), ev, rd);
    stepEv("R3 full", OP_SW, 1, 0, 32, 0, ESND | EINT | EBC);
    peekSend("R3 entry31", 31, 8'h9F);

    // R9 I2C block read
    stepEv("R9 start", OP_SI, 1, 0, 0, 0, EFET | EBS);
    stepEv("R9 byte1", OP_RB, 1, 0, 0, 8'hD1, EBD);
    stepRd("R9 hold while buffered", 1, 8'hD1);
    stepEv("R9 ack", OP_AK, 1, 0, 0, 0, EFET);
    stepEv("R9 byte2", OP_RB, 1, 0, 0, 8'hD2, EBD);
    stepEv("R9 last ack", OP_AK, 1, 1, 0, 0, EFET | ESTP);
    stepEv("R9 final", OP_RB, 1, 1, 0, 8'hD3, EINT | EBC);
    stepRd("R9 final hold", 0, 8'hD3);

    // R8 abort of an I2C read
    stepEv("R9 start2", OP_SI, 1, 0, 0, 0, EFET | EBS);
    stepEv("R8 abort i2c", OP_SW, 1, 0, 2, 0, ESTP | EERR);
    // R8 abort of a byte-paced write resets the index
    stepEv("R5 start", OP_SW, 0, 0, 5, 0, EBS | EBD);
    stepEv("R11", OP_WR, 0, 0, 5, 8'h90, E0);
    stepEv("R6 mid", OP_AK, 0, 0, 5, 0, EBD);
    stepEv("R8 abort idx", OP_SW, 1, 0, 0, 0, ESND | EINT | EBC);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule